// File: doc/BRIEF.md
# Dual-Clock Buffer with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose producer and consumer run on separate, unrelated clocks. The producer pushes words on the write clock and the consumer pulls them into an output register on the read clock. A tri-state data bus presents that register whenever the output enable is low. Four active-low status flags are provided. Empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. Each side judges the fill level from its own pointer and a synchronised copy of the other side's Gray-coded pointer.

A shared pin on the write side is sampled while reset is held low. If the pin is high, the block uses two write enables. If it is low, the block runs in threshold-loading mode: the same pin becomes a load strobe, and with it the producer writes the two 16-bit threshold values eight bits at a time. Both thresholds return to 7 on every reset. The storage depth is a parameter and must be a power of two (256 by default).

Top module: `dcf_fifo_flags`

## Requirements
- R1: A low `rstN` puts both pointers at the first slot and clears the output register to 0. It drives `emptyN` and `almostEmptyN` low and `fullN` and `almostFullN` high, and it sets both thresholds back to 7.
- R2: If `wrEn2Ld` is high while reset is applied, writes need `wrEn1N` low together with `wrEn2Ld` high. With `wrEn2Ld` low, no word is stored.
- R3: A word moves into the output register on a rising `rdClk` only when `rdEn1N` and `rdEn2N` are both low. In every other case the register keeps its value.
- R4: While `fullN` is low, write requests store nothing. While `emptyN` is low, read requests leave the output register and the read pointer unchanged.
- R5: `emptyN` changes on `rdClk` and is low when no words are held. `fullN` changes on `wrClk` and is low when DEPTH words are held.
- R6: `almostEmptyN` is low when the fill level is at or below the empty threshold. `almostFullN` is low when the fill level plus the full threshold reaches DEPTH or more. Both flags also hold when empty or full holds.
- R7: With `outEnN` high, `qOut` is high-impedance. With `outEnN` low, `qOut` shows the output register.
- R8: If `wrEn2Ld` is low while reset is applied, `wrEn2Ld` high with `wrEn1N` low is a normal write. `wrEn2Ld` low with `wrEn1N` low stores `dIn[7:0]` into one threshold byte per `wrClk` edge and stores no data word. The bytes are taken in a fixed cycle: empty threshold low byte, empty threshold high byte, full threshold low byte, full threshold high byte, then back to the start. An interrupted sequence resumes at the next byte.
- R9: Words leave in the order they were written under unrelated clocks. A flag may release late by the synchroniser delay, but it never reports space or data that does not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low reset for both clock domains |
| wrClk | input | 1 | Write clock |
| wrEn1N | input | 1 | Primary write enable, active low |
| wrEn2Ld | input | 1 | Second write enable or threshold load strobe, depending on the mode sampled at reset |
| dIn | input | W | Write data; bits 7:0 also carry threshold bytes |
| rdClk | input | 1 | Read clock |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2N | input | 1 | Second read enable, active low |
| outEnN | input | 1 | Output bus enable, active low |
| qOut | output | W | Output register on a tri-state bus |
| emptyN | output | 1 | Low when empty (read clock) |
| almostEmptyN | output | 1 | Low when at or below the empty threshold (read clock) |
| almostFullN | output | 1 | Low when within the full threshold of DEPTH (write clock) |
| fullN | output | 1 | Low when full (write clock) |

## Verification
A read that fires at a rising `rdClk` updates the output register at that same edge. The bench therefore drives enables and samples `qOut` at falling read edges, comparing each word against the reference queue one half-cycle after the edge that loaded it. The full flags fall at the write edge that stores the last word, and the empty flags fall at the read edge that takes the last word. A release on the far side needs up to three edges of that side's clock: two synchroniser stages plus the flag register. Before every flag comparison, the bench therefore idles six edges of each clock and then checks all four flags against the reference fill level.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // threshold bytes arrive eight bits per load cycle
  localparam int OFS_CHUNK = 8;
  localparam int OFS_W     = 2 * OFS_CHUNK;
  localparam int OFS_RESET = 7;

  // strobes from the two control halves into the storage datapath
  typedef struct packed {
    logic memWr;
    logic outLd;
  } dpStrobe_t;

  // order in which threshold bytes are written; the sequence is behaviour
  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofsSel_e;
endpackage

// File: rtl/dcf_gsync.sv
`timescale 1ns/1ps
module dcf_gsync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wctl.sv
`timescale 1ns/1ps
module dcf_wctl import dcf_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 wrClk,
  input  logic                 rstN,
  input  logic                 wrEn1N,
  input  logic                 wrEn2Ld,
  input  logic [OFS_CHUNK-1:0] ldData,
  input  logic [AW:0]          rdGraySync,
  output logic [AW:0]          wrGray,
  output logic [AW-1:0]        wrAddr,
  output logic                 memWr,
  output logic [OFS_W-1:0]     emptyOfs,
  output logic                 fullN,
  output logic                 almostFullN
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0]    DEPTH_P  = PW'(DEPTH);
  localparam logic [OFS_W:0]   DEPTH_S  = (OFS_W+1)'(DEPTH);
  localparam logic [OFS_W-1:0] OFS_DEF  = OFS_W'(OFS_RESET);

  logic            inReset;
  logic            progMode;
  logic [PW-1:0]   wrBin, wrBinNext, rdBinSync, fillNow, fillNext;
  logic [OFS_W-1:0] fullOfs;
  logic [OFS_W:0]  afSum;
  ofsSel_e         ldSel;
  logic            push, ofsLoad;

  // reset window flag: high while reset is low and for the first edge after
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) inReset <= 1'b1;
    else       inReset <= 1'b0;
  end

  // write-port mode sampled from the shared pin during the reset window
  always_ff @(posedge wrClk) begin
    if (inReset) progMode <= ~wrEn2Ld;
  end

  // same write condition in both modes; the load strobe only matters in progMode
  assign push    = ~wrEn1N & wrEn2Ld & fullN;
  assign ofsLoad = progMode & ~inReset & ~wrEn1N & ~wrEn2Ld;

  // Gray to binary for the synchronised read pointer
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rdBinSync[i] = ^rdGraySync[PW-1:i];
  end

  assign wrBinNext = wrBin + PW'(push);
  assign fillNow   = wrBin - rdBinSync;
  assign fillNext  = wrBinNext - rdBinSync;
  assign afSum     = (OFS_W+1)'(fillNext) + (OFS_W+1)'(fullOfs);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wrBin       <= wrBinNext;
      wrGray      <= wrBinNext ^ (wrBinNext >> 1);
      fullN       <= (fillNext != DEPTH_P);
      almostFullN <= (afSum < DEPTH_S);
    end
  end

  // threshold registers, one byte per load cycle in fixed order
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOfs <= OFS_DEF;
      fullOfs  <= OFS_DEF;
      ldSel    <= SEL_EMPTY_LO;
    end else if (ofsLoad) begin
      unique case (ldSel)
        SEL_EMPTY_LO: emptyOfs[OFS_CHUNK-1:0]     <= ldData;
        SEL_EMPTY_HI: emptyOfs[OFS_W-1:OFS_CHUNK] <= ldData;
        SEL_FULL_LO:  fullOfs[OFS_CHUNK-1:0]      <= ldData;
        SEL_FULL_HI:  fullOfs[OFS_W-1:OFS_CHUNK]  <= ldData;
      endcase
      ldSel <= ofsSel_e'(ldSel + 2'd1);
    end
  end

  assign wrAddr = wrBin[AW-1:0];
  assign memWr  = push;

  // R4: a full buffer takes no word
  a_r4_full_blocks_write: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrBin));
  // R2: the second enable / load strobe low never advances the write pointer
  a_r2_ld_low_no_push: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrEn2Ld |=> $stable(wrBin));
  // R5: the write side never sees more than DEPTH words
  a_r5_fill_bounded: assert property (@(posedge wrClk) disable iff (!rstN)
    fillNow <= DEPTH_P);
  // R6: full implies almost-full
  a_r6_full_in_almost: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);
  // R8: each load cycle moves to the next threshold byte
  a_r8_load_advances: assert property (@(posedge wrClk) disable iff (!rstN)
    ofsLoad |=> (ldSel != $past(ldSel)));
endmodule

// File: rtl/dcf_rctl.sv
`timescale 1ns/1ps
module dcf_rctl import dcf_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             rdEn1N,
  input  logic             rdEn2N,
  input  logic [AW:0]      wrGraySync,
  input  logic [OFS_W-1:0] emptyOfs,
  output logic [AW:0]      rdGray,
  output logic [AW-1:0]    rdAddr,
  output logic             outLd,
  output logic             emptyN,
  output logic             almostEmptyN
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rdBin, rdBinNext, wrBinSync, fillNext;
  logic          pop;

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign wrBinSync[i] = ^wrGraySync[PW-1:i];
  end

  assign pop       = ~rdEn1N & ~rdEn2N & emptyN;
  assign rdBinNext = rdBin + PW'(pop);
  assign fillNext  = wrBinSync - rdBinNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdBin        <= rdBinNext;
      rdGray       <= rdBinNext ^ (rdBinNext >> 1);
      emptyN       <= (fillNext != '0);
      almostEmptyN <= (OFS_W'(fillNext) > emptyOfs);
    end
  end

  assign rdAddr = rdBin[AW-1:0];
  assign outLd  = pop;

  // R4: an empty buffer gives no word
  a_r4_empty_blocks_read: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdBin));
  // R3: a single enable never advances the read pointer
  a_r3_one_enable_no_pop: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn1N || rdEn2N) |=> $stable(rdBin));
  // R6: empty implies almost-empty
  a_r6_empty_in_almost: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);
  // R9: the pointer sent across the clock boundary changes at most one bit per edge
  a_r9_gray_step: assert property (@(posedge rdClk) disable iff (!rstN)
    $onehot0(rdGray ^ $past(rdGray)));
endmodule

// File: rtl/dcf_dpath.sv
`timescale 1ns/1ps
module dcf_dpath import dcf_pkg::*; #(
  parameter int W     = 9,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  dpStrobe_t     stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [W-1:0]  dIn,
  input  logic          outEnN,
  output logic [W-1:0]  qOut
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.memWr) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          outReg <= '0;
    else if (stb.outLd) outReg <= mem[rdAddr];
  end

  assign qOut = outEnN ? {W{1'bz}} : outReg;

  // R3: without a read strobe the output register holds
  a_r3_out_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.outLd |=> $stable(outReg));
endmodule

// File: rtl/dcf_fifo_flags.sv
`timescale 1ns/1ps
module dcf_fifo_flags import dcf_pkg::*; #(
  parameter int W     = 9,
  parameter int DEPTH = 256
) (
  input  logic         rstN,
  input  logic         wrClk,
  input  logic         wrEn1N,
  input  logic         wrEn2Ld,
  input  logic [W-1:0] dIn,
  input  logic         rdClk,
  input  logic         rdEn1N,
  input  logic         rdEn2N,
  input  logic         outEnN,
  output logic [W-1:0] qOut,
  output logic         emptyN,
  output logic         almostEmptyN,
  output logic         almostFullN,
  output logic         fullN
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]      wrGray, rdGray, wrGraySync, rdGraySync;
  logic [AW-1:0]    wrAddr, rdAddr;
  logic [OFS_W-1:0] emptyOfs;
  logic             memWr, outLd;
  dpStrobe_t        stb;

  assign stb.memWr = memWr;
  assign stb.outLd = outLd;

  dcf_wctl #(.DEPTH(DEPTH), .AW(AW)) u_wctl (
    .wrClk(wrClk), .rstN(rstN), .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld),
    .ldData(dIn[OFS_CHUNK-1:0]), .rdGraySync(rdGraySync), .wrGray(wrGray),
    .wrAddr(wrAddr), .memWr(memWr), .emptyOfs(emptyOfs),
    .fullN(fullN), .almostFullN(almostFullN)
  );

  dcf_rctl #(.DEPTH(DEPTH), .AW(AW)) u_rctl (
    .rdClk(rdClk), .rstN(rstN), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .wrGraySync(wrGraySync), .emptyOfs(emptyOfs), .rdGray(rdGray),
    .rdAddr(rdAddr), .outLd(outLd), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  dcf_gsync #(.W(AW+1)) u_w2r (.clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync));
  dcf_gsync #(.W(AW+1)) u_r2w (.clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync));

  dcf_dpath #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dIn(dIn), .outEnN(outEnN), .qOut(qOut)
  );
endmodule

// File: tb/sim_dcf_fifo_flags.sv
`timescale 1ns/1ps
module sim_dcf_fifo_flags;
  localparam int W     = 9;
  localparam int DEPTH = 256;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b1;
  logic wrEn1N = 1'b1, wrEn2Ld = 1'b1, rdEn1N = 1'b1, rdEn2N = 1'b1, outEnN = 1'b0;
  logic [W-1:0] dIn = '0;
  wire  [W-1:0] qOut;
  logic emptyN, almostEmptyN, almostFullN, fullN;

  dcf_fifo_flags #(.W(W), .DEPTH(DEPTH)) u0 (
    .rstN(rstN), .wrClk(wrClk), .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .dIn(dIn),
    .rdClk(rdClk), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .outEnN(outEnN), .qOut(qOut),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .fullN(fullN)
  );

  always #10   wrClk = ~wrClk;   // 50 MHz write clock
  always #13.5 rdClk = ~rdClk;   // unrelated read clock

  int nChk = 0, nBad = 0;
  logic [W-1:0] model[$];
  logic [W-1:0] expQ = '0;
  int  eOfs = 7, fOfs = 7, ldSel = 0;
  bit  progM = 1'b0;
  bit  done  = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(bit ld);
    rstN = 1'b0; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1; wrEn2Ld = ld;
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    @(negedge wrClk);
    wrEn2Ld = 1'b1;
    model.delete(); expQ = '0; eOfs = 7; fOfs = 7; ldSel = 0; progM = !ld;
  endtask

  task automatic wrCycle(bit en, bit ld, logic [W-1:0] d);
    @(negedge wrClk);
    wrEn1N = ~en; wrEn2Ld = ld; dIn = d;
    if (en && ld && fullN) model.push_back(d);
    if (en && !ld && progM) begin
      case (ldSel)
        0: eOfs = (eOfs & 'hFF00) | int'(d[7:0]);
        1: eOfs = (eOfs & 'h00FF) | (int'(d[7:0]) << 8);
        2: fOfs = (fOfs & 'hFF00) | int'(d[7:0]);
        default: fOfs = (fOfs & 'h00FF) | (int'(d[7:0]) << 8);
      endcase
      ldSel = (ldSel + 1) % 4;
    end
  endtask

  task automatic wrIdle();
    @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
  endtask

  // checks the word loaded at the previous read edge, then sets up the next read
  task automatic rdCycle(bit r1, bit r2);
    @(negedge rdClk);
    if (!outEnN) check(qOut == expQ, "R3 R9 output word", int'(qOut), int'(expQ));
    rdEn1N = ~r1; rdEn2N = ~r2;
    if (r1 && r2 && emptyN) begin
      if (model.size() == 0) check(1'b0, "R9 flag shows data never written", 1, 0);
      else expQ = model.pop_front();
    end
  endtask

  task automatic settle();
    wrIdle();
    repeat (6) rdCycle(1'b0, 1'b0);
    repeat (6) @(negedge wrClk);
  endtask

  task automatic checkFlags(string req);
    int n = model.size();
    check(emptyN == (n != 0), {req, " emptyN"}, int'(emptyN), int'(n != 0));
    check(fullN == (n != DEPTH), {req, " fullN"}, int'(fullN), int'(n != DEPTH));
    check(almostEmptyN == !(n <= eOfs), {req, " almostEmptyN"}, int'(almostEmptyN), int'(!(n <= eOfs)));
    check(almostFullN == !(n + fOfs >= DEPTH), {req, " almostFullN"}, int'(almostFullN), int'(!(n + fOfs >= DEPTH)));
  endtask

  task automatic fillTo(int n);
    while (model.size() < n) wrCycle(1'b1, 1'b1, W'($urandom));
    wrIdle();
  endtask

  task automatic drainTo(int n);
    while (model.size() > n) rdCycle(1'b1, 1'b1);
    rdCycle(1'b0, 1'b0);
  endtask

  task automatic fillCheck(int n, string req);
    fillTo(n); settle(); checkFlags(req);
  endtask

  task automatic drainCheck(int n, string req);
    drainTo(n); settle(); checkFlags(req);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, dual-enable mode
    doReset(1'b1);
    repeat (2) rdCycle(1'b0, 1'b0);
    check(qOut == '0, "R1 output register cleared", int'(qOut), 0);
    checkFlags("R1 reset flags");

    // R2: second enable low stores nothing in dual-enable mode
    repeat (3) wrCycle(1'b1, 1'b0, 9'h155);
    repeat (2) wrCycle(1'b0, 1'b1, 9'h0aa);
    settle(); checkFlags("R2 no write without both enables");
    for (int i = 0; i < 10; i++) wrCycle(1'b1, 1'b1, W'(9'h100 + i));
    settle(); checkFlags("R2 ten words stored");

    // R3: one read enable alone moves nothing
    repeat (3) rdCycle(1'b1, 1'b0);
    repeat (3) rdCycle(1'b0, 1'b1);
    settle(); checkFlags("R3 single enable leaves fill level");

    // R7: bus release and drive
    rdCycle(1'b1, 1'b1); rdCycle(1'b0, 1'b0);
    outEnN = 1'b1; #1;
    check(qOut === {W{1'bz}}, "R7 bus released", int'(qOut), 0);
    outEnN = 1'b0; #1;
    check(qOut == expQ, "R7 bus driven", int'(qOut), int'(expQ));

    // R4: reads on empty ignored
    drainTo(0);
    repeat (4) rdCycle(1'b1, 1'b1);
    settle(); checkFlags("R4 reads on empty ignored");

    // R6 default thresholds and R4/R5 full behaviour
    fillCheck(7, "R6 default empty threshold at 7");
    fillCheck(8, "R6 default empty threshold at 8");
    fillCheck(DEPTH - 8, "R6 default full threshold below");
    fillCheck(DEPTH - 7, "R6 default full threshold at");
    fillCheck(DEPTH, "R5 full");
    repeat (5) wrCycle(1'b1, 1'b1, 9'h1ff);
    settle(); checkFlags("R4 writes on full ignored");
    drainCheck(DEPTH - 1, "R5 full released");
    drainCheck(0, "R4 overflow words not stored");

    // R8: threshold loading mode
    doReset(1'b0);
    wrCycle(1'b1, 1'b0, 9'd20); wrCycle(1'b1, 1'b0, 9'd0); wrIdle();
    fillTo(5);
    wrCycle(1'b1, 1'b0, 9'd30); wrCycle(1'b1, 1'b0, 9'd0); wrIdle();
    settle(); checkFlags("R8 split load, no data from loads");
    fillCheck(20, "R8 empty threshold at 20");
    fillCheck(21, "R8 empty threshold at 21");
    fillCheck(DEPTH - 31, "R8 full threshold below");
    fillCheck(DEPTH - 30, "R8 full threshold at");
    wrCycle(1'b1, 1'b0, 9'd40); wrIdle();
    drainCheck(41, "R8 load sequence wraps to empty low byte");
    drainCheck(40, "R8 wrapped threshold at 40");
    drainCheck(0, "R8 drained");

    // R1: reset restores defaults and clears the output
    doReset(1'b1);
    rdCycle(1'b0, 1'b0);
    check(qOut == '0, "R1 output cleared after data", int'(qOut), 0);
    fillCheck(7, "R1 thresholds restored at 7");
    fillCheck(8, "R1 thresholds restored at 8");
    drainCheck(0, "R1 drained");

    // R9: unrelated clocks with random traffic
    fork
      begin
        for (int i = 0; i < 1500; i++)
          wrCycle($urandom_range(0, 99) < 80, $urandom_range(0, 9) != 0, W'($urandom));
        for (int i = 0; i < 1500; i++)
          wrCycle($urandom_range(0, 99) < 25, $urandom_range(0, 9) != 0, W'($urandom));
        wrIdle();
      end
      begin
        for (int i = 0; i < 1100; i++)
          rdCycle($urandom_range(0, 99) < 75, $urandom_range(0, 99) < 75);
        for (int i = 0; i < 1100; i++)
          rdCycle($urandom_range(0, 99) < 95, $urandom_range(0, 99) < 95);
        rdCycle(1'b0, 1'b0);
      end
    join
    settle(); checkFlags("R9 flags after random traffic");
    drainCheck(0, "R9 drained in order");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule